// File: doc/BRIEF.md
# Two-Channel Configuration Register Bank with Staged Transfer

This block holds the byte-wide configuration registers of a two-channel data converter behind a plain parallel register port (address, write data, write strobe, read strobe, read data). Some registers are shared by the whole chip. Others exist once per channel. A write to a per-channel register goes to every channel that the channel-select register enables. This lets software program one channel, the other channel, or both channels with a single access.

Writes to the operating-mode registers land in staged copies. The field values driven out of the block come from separate live copies. A transfer command moves every staged copy into its live copy on one clock edge, so changes written at different times take effect together. The port configuration byte stores each of its two control bits twice, in mirrored positions, so the byte reads the same from either shift order. It also carries a soft-reset command, which returns every register to its default. The bank also has a fixed identifier byte, a speed-grade byte and a PLL-lock status byte, all read-only.

Top module: `cfg_bank_top`

## Requirements
- R1: After reset, the registers read 0x00→0x18, 0x05→0x03, 0x08→0x00, 0x09→0x01 and 0xFF→0x00. The live outputs are `pwr_mode`=0 and `ext_pin_standby`=0 for every channel, `dcs_enable`=1 and `lsb_first`=0.
- R2: The byte at 0x00 is mirrored. Writing 1 to bit 6 or bit 1 sets the shift-order flag, and the flag reads back in both bit 6 and bit 1. Bits 5 and 2 do the same for soft reset. Bits 4 and 3 always read 1, and bits 7 and 0 always read 0. `lsb_first` follows the flag from the edge that performs the write.
- R3: A write to 0x00 changes nothing unless both bits of the channel-select register are 1.
- R4: Address 0x01 always reads 0x7E, and writes to it have no effect.
- R5: Address 0x02 returns the `grade_code` input in bits [5:4] and 0 in its other bits. Address 0x0A returns `pll_locked` in bit 7 and 0 in its other bits. Writes to either address have no effect.
- R6: Address 0x05 is the channel select: bit 0 is channel A and bit 1 is channel B. A write to 0x08 updates the staged copy of every selected channel and leaves unselected channels unchanged. With a select of 0, no channel is updated.
- R7: A read of 0x08 returns channel A's staged value when select bit 0 is 1, and channel B's staged value otherwise.
- R8: Writes to 0x08 and 0x09 do not change `pwr_mode`, `ext_pin_standby` or `dcs_enable` until a transfer occurs.
- R9: A write of 1 to bit 0 of 0xFF makes 0xFF read 0x01 until the next edge. On that edge every staged copy is moved into its live copy, and the bit clears, so 0xFF reads 0x00.
- R10: A write to 0x00 with bit 5 or bit 2 set, made while both select bits are 1, makes 0x00 read with the soft-reset bits set until the next edge. On that edge every staged register, every live register and the channel select return to their R1 defaults, and the soft-reset bits clear.
- R11: Addresses other than 0x00, 0x01, 0x02, 0x05, 0x08, 0x09, 0x0A and 0xFF read 0x00, and writes to them change no register.
- R12: At 0x08, bits [1:0] are the power mode (00 normal, 01 full power-down, 10 standby, 11 reserved) and bit 5 is the external-pin behaviour (0 power-down, 1 standby). All other bits read 0. In `pwr_mode`, channel c occupies bits [2c+1:2c], and bit c of `ext_pin_standby` belongs to channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one access per cycle |
| reg_rd | input | 1 | Read strobe; read data is combinational |
| reg_rdata | output | 8 | Read data, 0 when `reg_rd` is low |
| grade_code | input | 2 | Static speed-grade code |
| pll_locked | input | 1 | PLL lock status |
| lsb_first | output | 1 | Shift-order flag from 0x00 |
| dcs_enable | output | 1 | Live duty-cycle stabilizer enable |
| pwr_mode | output | 2*NUM_CH | Live power mode per channel |
| ext_pin_standby | output | NUM_CH | Live external-pin behaviour per channel |

## Verification
The bench builds the bank with its defaults: `NUM_CH` = 2 and the identifier 0x7E. With two channels, every select pattern (none, A only, B only, both) can be driven, including the case where the read steering falls back to channel B. Because there are exactly two select bits, the "all selected" gate on 0x00 and the mirrored soft-reset path are both reachable. A separate directed scenario covers each of these alongside the transfer timing.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] ADR_PORTCFG = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_CHIPID  = 8'h01;
    localparam logic [ADDR_W-1:0] ADR_GRADE   = 8'h02;
    localparam logic [ADDR_W-1:0] ADR_CHSEL   = 8'h05;
    localparam logic [ADDR_W-1:0] ADR_PWR     = 8'h08;
    localparam logic [ADDR_W-1:0] ADR_CLK     = 8'h09;
    localparam logic [ADDR_W-1:0] ADR_PLL     = 8'h0A;
    localparam logic [ADDR_W-1:0] ADR_XFER    = 8'hFF;

    typedef enum logic [1:0] {
        PM_NORMAL  = 2'b00,
        PM_OFF     = 2'b01,
        PM_STANDBY = 2'b10,
        PM_RSVD    = 2'b11
    } pwr_mode_e;

    typedef struct packed {
        logic      ext_standby;
        pwr_mode_e mode;
    } chan_fields_t;

    localparam chan_fields_t CHAN_DEFAULT = '{ext_standby: 1'b0, mode: PM_NORMAL};

    typedef struct packed {
        logic portcfg;
        logic chsel;
        logic pwr;
        logic clk;
        logic xfer;
    } wr_dec_t;

    function automatic wr_dec_t decode_write(logic [ADDR_W-1:0] a, logic we);
        wr_dec_t d;
        d.portcfg = we && (a == ADR_PORTCFG);
        d.chsel   = we && (a == ADR_CHSEL);
        d.pwr     = we && (a == ADR_PWR);
        d.clk     = we && (a == ADR_CLK);
        d.xfer    = we && (a == ADR_XFER);
        return d;
    endfunction

    function automatic logic [REG_W-1:0] pack_portcfg(logic lsb, logic srst);
        return {1'b0, lsb, srst, 1'b1, 1'b1, srst, lsb, 1'b0};
    endfunction

    function automatic logic [REG_W-1:0] pack_chan(chan_fields_t f);
        return {2'b00, f.ext_standby, 3'b000, f.mode};
    endfunction

endpackage

// File: rtl/cfg_chan_regs.sv
module cfg_chan_regs
    import cfg_bank_pkg::*;
(
    input  logic         clk,
    input  logic         clr_i,
    input  logic         wr_i,
    input  chan_fields_t wfld_i,
    input  logic         xfer_i,
    output chan_fields_t shd_o,
    output chan_fields_t act_o
);

    chan_fields_t shd_q, act_q;

    always_ff @(posedge clk) begin
        if (clr_i) begin
            shd_q <= CHAN_DEFAULT;
            act_q <= CHAN_DEFAULT;
        end else begin
            if (wr_i)   shd_q <= wfld_i;
            if (xfer_i) act_q <= shd_q;
        end
    end

    assign shd_o = shd_q;
    assign act_o = act_q;

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (clr_i)
        !xfer_i |=> $stable(act_q)); // R8
    AST_XFER_COPY: assert property (@(posedge clk) disable iff (clr_i)
        xfer_i |=> act_q == $past(shd_q)); // R9
    AST_UNSEL_KEEP: assert property (@(posedge clk) disable iff (clr_i)
        !wr_i |=> $stable(shd_q)); // R6

endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
    import cfg_bank_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_i,
    input  logic              clr_i,
    input  wr_dec_t           wr_i,
    input  logic              lsb_bit_i,
    input  logic              srst_bit_i,
    input  logic [NUM_CH-1:0] chsel_wd_i,
    input  logic              bit0_i,
    output logic              lsb_o,
    output logic              srst_o,
    output logic [NUM_CH-1:0] chsel_o,
    output logic              dcs_shd_o,
    output logic              dcs_act_o,
    output logic              xfer_o
);

    logic              lsb_q, srst_q, dcs_shd_q, dcs_act_q, xfer_q;
    logic [NUM_CH-1:0] chsel_q;
    logic              cfg_open;

    assign cfg_open = &chsel_q;

    always_ff @(posedge clk) begin
        if (clr_i) begin
            lsb_q     <= 1'b0;
            srst_q    <= 1'b0;
            chsel_q   <= '1;
            dcs_shd_q <= 1'b1;
            dcs_act_q <= 1'b1;
            xfer_q    <= 1'b0;
        end else begin
            if (wr_i.portcfg && cfg_open) begin
                lsb_q  <= lsb_bit_i;
                srst_q <= srst_bit_i;
            end
            if (wr_i.chsel) chsel_q   <= chsel_wd_i;
            if (wr_i.clk)   dcs_shd_q <= bit0_i;
            if (xfer_q) begin
                dcs_act_q <= dcs_shd_q;
                xfer_q    <= 1'b0;
            end else if (wr_i.xfer) begin
                xfer_q <= bit0_i;
            end
        end
    end

    assign lsb_o     = lsb_q;
    assign srst_o    = srst_q;
    assign chsel_o   = chsel_q;
    assign dcs_shd_o = dcs_shd_q;
    assign dcs_act_o = dcs_act_q;
    assign xfer_o    = xfer_q;

    AST_XFER_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst_i)
        xfer_q |=> !xfer_q); // R9
    AST_SRST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst_i)
        srst_q |=> !srst_q && chsel_q == '1 && dcs_act_q); // R10
    AST_PORTCFG_GATED: assert property (@(posedge clk) disable iff (clr_i)
        (wr_i.portcfg && !cfg_open) |=> $stable(lsb_q) && $stable(srst_q)); // R3
    AST_DCS_HOLD: assert property (@(posedge clk) disable iff (clr_i)
        !xfer_q |=> $stable(dcs_act_q)); // R8

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfg_bank_pkg::*;
#(
    parameter int               NUM_CH  = 2,
    parameter logic [REG_W-1:0] CHIP_ID = 8'h7E
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              lsb_i,
    input  logic              srst_i,
    input  logic [NUM_CH-1:0] chsel_i,
    input  chan_fields_t      shd_i [NUM_CH],
    input  logic              dcs_shd_i,
    input  logic              xfer_i,
    input  logic [1:0]        grade_i,
    input  logic              pll_i,
    output logic [REG_W-1:0]  rdata_o
);

    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [SEL_W-1:0] rd_ch;
    logic [REG_W-1:0] val;

    always_comb begin
        rd_ch = SEL_W'(NUM_CH - 1);
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (chsel_i[c]) rd_ch = SEL_W'(c);
        end
    end

    always_comb begin
        case (addr_i)
            ADR_PORTCFG: val = pack_portcfg(lsb_i, srst_i);
            ADR_CHIPID:  val = CHIP_ID;
            ADR_GRADE:   val = {2'b00, grade_i, 4'b0000};
            ADR_CHSEL:   val = REG_W'(chsel_i);
            ADR_PWR:     val = pack_chan(shd_i[rd_ch]);
            ADR_CLK:     val = {7'b0, dcs_shd_i};
            ADR_PLL:     val = {pll_i, 7'b0};
            ADR_XFER:    val = {7'b0, xfer_i};
            default:     val = '0;
        endcase
        rdata_o = rd_i ? val : '0;
    end

endmodule

// File: rtl/cfg_bank_top.sv
module cfg_bank_top
    import cfg_bank_pkg::*;
#(
    parameter int               NUM_CH  = 2,
    parameter logic [REG_W-1:0] CHIP_ID = 8'h7E
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic [1:0]            grade_code,
    input  logic                  pll_locked,
    output logic                  lsb_first,
    output logic                  dcs_enable,
    output logic [2*NUM_CH-1:0]   pwr_mode,
    output logic [NUM_CH-1:0]     ext_pin_standby
);

    wr_dec_t           wdec;
    logic              clr, srst, xfer, dcs_shd;
    logic [NUM_CH-1:0] chsel;
    chan_fields_t      wfld;
    chan_fields_t      shd [NUM_CH];
    chan_fields_t      act [NUM_CH];

    assign wdec = decode_write(reg_addr, reg_wr);
    assign clr  = rst || srst;
    assign wfld = '{ext_standby: reg_wdata[5], mode: pwr_mode_e'(reg_wdata[1:0])};

    cfg_global_regs #(.NUM_CH(NUM_CH)) u_glob (
        .clk        (clk),
        .rst_i      (rst),
        .clr_i      (clr),
        .wr_i       (wdec),
        .lsb_bit_i  (reg_wdata[6] | reg_wdata[1]),
        .srst_bit_i (reg_wdata[5] | reg_wdata[2]),
        .chsel_wd_i (reg_wdata[NUM_CH-1:0]),
        .bit0_i     (reg_wdata[0]),
        .lsb_o      (lsb_first),
        .srst_o     (srst),
        .chsel_o    (chsel),
        .dcs_shd_o  (dcs_shd),
        .dcs_act_o  (dcs_enable),
        .xfer_o     (xfer)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cfg_chan_regs u_ch (
            .clk    (clk),
            .clr_i  (clr),
            .wr_i   (wdec.pwr && chsel[c]),
            .wfld_i (wfld),
            .xfer_i (xfer),
            .shd_o  (shd[c]),
            .act_o  (act[c])
        );
        assign pwr_mode[2*c +: 2]  = act[c].mode;
        assign ext_pin_standby[c]  = act[c].ext_standby;
    end

    cfg_read_mux #(.NUM_CH(NUM_CH), .CHIP_ID(CHIP_ID)) u_rd (
        .addr_i    (reg_addr),
        .rd_i      (reg_rd),
        .lsb_i     (lsb_first),
        .srst_i    (srst),
        .chsel_i   (chsel),
        .shd_i     (shd),
        .dcs_shd_i (dcs_shd),
        .xfer_i    (xfer),
        .grade_i   (grade_code),
        .pll_i     (pll_locked),
        .rdata_o   (reg_rdata)
    );

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |-> reg_rdata == '0); // R11

endmodule

// File: tb/cfg_bank_top_test.sv
module cfg_bank_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic [1:0] grade_code = 2'b00;
    logic       pll_locked = 1'b0;
    logic       lsb_first, dcs_enable;
    logic [3:0] pwr_mode;
    logic [1:0] ext_pin_standby;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    cfg_bank_top uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .grade_code(grade_code), .pll_locked(pll_locked),
        .lsb_first(lsb_first), .dcs_enable(dcs_enable),
        .pwr_mode(pwr_mode), .ext_pin_standby(ext_pin_standby)
    );

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
        reg_addr = a; reg_rd = 1'b1;
        #1;
        chk(req, reg_rdata, exp);
        reg_rd = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        rd_chk("R1 portcfg", 8'h00, 8'h18);
        rd_chk("R1 chsel", 8'h05, 8'h03);
        rd_chk("R1 pwr", 8'h08, 8'h00);
        rd_chk("R1 clk", 8'h09, 8'h01);
        rd_chk("R1 xfer", 8'hFF, 8'h00);
        chk("R1 pwr_mode", pwr_mode, 0);
        chk("R1 ext", ext_pin_standby, 0);
        chk("R1 dcs", dcs_enable, 1);
        chk("R1 lsb", lsb_first, 0);
        chk("R11 idle rdata", reg_rdata, 0);
    endtask

    task automatic t_mirror;
        wr(8'h00, 8'h40);
        rd_chk("R2 bit6", 8'h00, 8'h5A);
        chk("R2 lsb_first", lsb_first, 1);
        wr(8'h00, 8'h00);
        rd_chk("R2 clear", 8'h00, 8'h18);
        wr(8'h00, 8'h02);
        rd_chk("R2 bit1", 8'h00, 8'h5A);
        wr(8'h00, 8'h99);
        rd_chk("R2 fixed bits", 8'h00, 8'h18);
        chk("R2 lsb_first off", lsb_first, 0);
    endtask

    task automatic t_gate;
        wr(8'h05, 8'h01);
        wr(8'h00, 8'h42);
        rd_chk("R3 gated A", 8'h00, 8'h18);
        chk("R3 lsb held", lsb_first, 0);
        wr(8'h05, 8'h00);
        wr(8'h00, 8'h42);
        rd_chk("R3 gated none", 8'h00, 8'h18);
        wr(8'h05, 8'h03);
    endtask

    task automatic t_readonly;
        rd_chk("R4 id", 8'h01, 8'h7E);
        wr(8'h01, 8'h00);
        rd_chk("R4 id after write", 8'h01, 8'h7E);
        grade_code = 2'b10;
        rd_chk("R5 grade high", 8'h02, 8'h20);
        grade_code = 2'b00;
        rd_chk("R5 grade low", 8'h02, 8'h00);
        pll_locked = 1'b1;
        rd_chk("R5 pll", 8'h0A, 8'h80);
        wr(8'h0A, 8'h00);
        wr(8'h02, 8'hFF);
        rd_chk("R5 pll after write", 8'h0A, 8'h80);
        rd_chk("R5 grade after write", 8'h02, 8'h00);
        pll_locked = 1'b0;
        rd_chk("R5 pll low", 8'h0A, 8'h00);
    endtask

    task automatic t_steer;
        wr(8'h05, 8'h01);
        wr(8'h08, 8'h21);
        rd_chk("R6 A written", 8'h08, 8'h21);
        wr(8'h05, 8'h02);
        rd_chk("R7 B untouched", 8'h08, 8'h00);
        wr(8'h08, 8'hDE);
        rd_chk("R12 field mask", 8'h08, 8'h02);
        wr(8'h05, 8'h03);
        rd_chk("R7 both reads A", 8'h08, 8'h21);
        wr(8'h05, 8'h00);
        wr(8'h08, 8'h03);
        rd_chk("R6 none selected B", 8'h08, 8'h02);
        wr(8'h05, 8'h01);
        rd_chk("R6 none selected A", 8'h08, 8'h21);
    endtask

    task automatic t_transfer;
        wr(8'h09, 8'h00);
        rd_chk("R8 clk staged", 8'h09, 8'h00);
        chk("R8 dcs live held", dcs_enable, 1);
        chk("R8 pwr live held", pwr_mode, 0);
        chk("R8 ext live held", ext_pin_standby, 0);
        wr(8'hFF, 8'h01);
        rd_chk("R9 xfer pending", 8'hFF, 8'h01);
        chk("R9 live before copy", pwr_mode, 0);
        @(negedge clk);
        rd_chk("R9 xfer cleared", 8'hFF, 8'h00);
        chk("R9 pwr_mode", pwr_mode, 4'b1001);
        chk("R9 ext", ext_pin_standby, 2'b01);
        chk("R9 dcs", dcs_enable, 0);
        wr(8'h08, 8'h00);
        repeat (2) @(negedge clk);
        chk("R8 A live kept", pwr_mode, 4'b1001);
    endtask

    task automatic t_unsup;
        rd_chk("R11 addr 03", 8'h03, 8'h00);
        rd_chk("R11 addr 7F", 8'h7F, 8'h00);
        wr(8'h06, 8'hFF);
        wr(8'h0B, 8'hFF);
        rd_chk("R11 addr 06", 8'h06, 8'h00);
        rd_chk("R11 chsel kept", 8'h05, 8'h01);
        rd_chk("R11 pwr kept", 8'h08, 8'h00);
        rd_chk("R11 clk kept", 8'h09, 8'h00);
    endtask

    task automatic t_softreset;
        wr(8'h05, 8'h03);
        wr(8'h00, 8'h04);
        rd_chk("R10 pending", 8'h00, 8'h3C);
        @(negedge clk);
        rd_chk("R10 portcfg", 8'h00, 8'h18);
        rd_chk("R10 chsel", 8'h05, 8'h03);
        rd_chk("R10 pwr", 8'h08, 8'h00);
        rd_chk("R10 clk", 8'h09, 8'h01);
        chk("R10 pwr_mode", pwr_mode, 0);
        chk("R10 ext", ext_pin_standby, 0);
        chk("R10 dcs", dcs_enable, 1);
        wr(8'h05, 8'h02);
        rd_chk("R10 B shadow default", 8'h08, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mirror();
        t_gate();
        t_readonly();
        t_steer();
        t_transfer();
        t_unsup();
        t_softreset();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule